// File: doc/BRIEF.md
# Cascadable Complex FIR Segment

This block is one slice of a long complex FIR filter that is split across several identical slices. Every slice sees the same sample stream; each owns a fixed set of eight complex coefficients and contributes eight taps to every output. A slice takes a four-lane partial-sum vector from its upstream neighbour, adds its own eight-tap products to each lane and hands the vector downstream. The first slice starts from zero. The last slice turns its wide sums into 16-bit complex samples.

The slice is controlled by one state machine. From reset it passes through ST_SKIP, which discards the samples that belong to earlier slices. ST_SKIP is left on the transition "skip done" and is not entered at all in slice 0. ST_FILL follows and primes the history; it is left on "history primed". After that the slice cycles through three states. In ST_WAIT the slice waits until four staged samples (and, for a non-first slice, a cascade vector) are present and leaves on "step start". In ST_CALC it computes one lane per cycle and leaves on "last lane". In ST_SEND it offers the result and leaves on "result taken", which returns to ST_WAIT. New samples are staged during ST_CALC and ST_SEND, so the next step can begin at once.

The history is a 16-entry circular store made of four 4-sample quarters. The history is never cleared between steps, so filtering runs on without a break. The coefficients and the slice position are fixed by parameters.

Top module: `cfir_segment`

## Requirements
- R1: Slice k throws away its first 8·k accepted samples. It writes the next 8 samples into history slots 0..7 in arrival order and only then begins steps.
- R2: Step t (counted from 0 since reset) writes its 4 staged samples into quarter (t+2) mod 4, which is slots 4q..4q+3. Lane l then adds the sum over j=0..7 of c[j]·h[(4·(t mod 4)+l+j) mod 16], using complex multiplication. A sample, and coefficient j in the COEFS parameter at bits [32j+31:32j], carries its real part in the upper 16 bits and its imaginary part in the lower 16 bits.
- R3: The history carries over from step to step, so the output of step t equals the filter applied to the accepted sample sequence, with no restart.
- R4: A non-first slice starts each lane from the matching lane of one cascade vector. It consumes exactly one such vector per step, and a step does not start until that vector and 4 staged samples are both present. In a cascade vector, lane l holds its real part in bits [96l+95:96l+48] and its imaginary part in bits [96l+47:96l], both 48-bit two's complement.
- R5: The last slice outputs, per lane and per component, (v + 2^(SHIFT−1)) arithmetically shifted right by SHIFT and saturated to [−32768, 32767]. Lane l is placed with its real part at bits [32l+31:32l+16] and its imaginary part at bits [32l+15:32l].
- R6: The first slice never raises casc_ready, and its results do not depend on cascade inputs.
- R7: smp_ready is low only when 4 samples are already staged outside ST_SKIP and ST_FILL. No accepted sample is lost.
- R8: While out_valid is high and out_ready is low, out_valid stays high and out_data does not change.
- R9: When the cascade vector is already present, out_valid rises on the 5th rising edge after the edge that accepts the 4th sample of a step.
- R10: After reset, out_valid and casc_ready are low and smp_ready is high.
- R11: A non-last slice presents its four 48-bit lane sums unchanged on out_data, using the lane layout of R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample offered |
| smp_data | input | 2·SAMP_W | Complex sample, real part high |
| smp_ready | output | 1 | Sample can be taken |
| casc_valid | input | 1 | Upstream partial-sum vector offered |
| casc_data | input | LANES·2·ACC_W | Upstream four-lane partial sums |
| casc_ready | output | 1 | Partial-sum vector taken this cycle |
| out_valid | output | 1 | Result vector offered |
| out_data | output | OUT_W | Partial sums, or rounded samples in the last slice |
| out_ready | input | 1 | Downstream takes the result |

## Verification
Each result falls due five rising edges after the edge that takes the fourth sample of a step, provided the cascade vector is waiting. One directed test counts those edges on falling edges and expects out_valid low on the first four and high on the fifth. In all other cases the bench waits on the handshake, reading out_valid and out_data on falling edges. It therefore compares each result with its computed value in the cycle before the edge on which the result is taken. During an eight-cycle stall it re-reads the held output every falling edge. Values at the end of the stall show that the sample input has filled and stopped, and the later results show that no sample was dropped.

// File: rtl/cfir_pkg.sv
package cfir_pkg;

    localparam int QUARTERS = 4;

    typedef enum logic [2:0] {
        ST_SKIP,
        ST_FILL,
        ST_WAIT,
        ST_CALC,
        ST_SEND
    } seg_state_t;

endpackage

// File: rtl/cfir_history.sv
module cfir_history
    import cfir_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int SAMP_W = 16,
    localparam int HIST_N = QUARTERS * LANES,
    localparam int HW     = $clog2(HIST_N),
    localparam int CW     = $clog2(LANES + 1),
    localparam int SW     = 2 * SAMP_W
)(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SW-1:0]        din,
    input  logic                 fill_we,
    input  logic [HW-1:0]        fill_idx,
    input  logic                 stage_push,
    input  logic                 commit,
    input  logic [1:0]           quarter,
    output logic [HIST_N*SW-1:0] hist_flat,
    output logic [CW-1:0]        stage_cnt
);

    localparam int LW = $clog2(LANES);

    logic [SW-1:0] hist_q  [HIST_N];
    logic [SW-1:0] stage_q [LANES];
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < HIST_N; i++) hist_q[i] <= '0;
            for (int i = 0; i < LANES; i++) stage_q[i] <= '0;
            cnt_q <= '0;
        end else begin
            if (fill_we) hist_q[fill_idx] <= din;
            if (commit) begin
                for (int i = 0; i < LANES; i++)
                    hist_q[int'(quarter) * LANES + i] <= stage_q[i];
            end
            if (stage_push) stage_q[cnt_q[LW-1:0]] <= din;
            if (commit)          cnt_q <= '0;
            else if (stage_push) cnt_q <= cnt_q + 1'b1;
        end
    end

    assign stage_cnt = cnt_q;

    for (genvar i = 0; i < HIST_N; i++) begin : g_flat
        assign hist_flat[i*SW +: SW] = hist_q[i];
    end

    // R7: the staging store is never written past its capacity
    a_r7_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        stage_push |-> (cnt_q < CW'(LANES)));

    // R4: a step only starts from a full set of staged samples
    a_r4_commit_full: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (cnt_q == CW'(LANES)));

endmodule

// File: rtl/cfir_lane_mac.sv
module cfir_lane_mac
    import cfir_pkg::*;
#(
    parameter int TAPS   = 8,
    parameter int LANES  = 4,
    parameter int SAMP_W = 16,
    parameter int ACC_W  = 48,
    parameter logic [TAPS*2*SAMP_W-1:0] COEFS = '0,
    localparam int HIST_N = QUARTERS * LANES,
    localparam int HW     = $clog2(HIST_N),
    localparam int SW     = 2 * SAMP_W
)(
    input  logic [HIST_N*SW-1:0]     hist_flat,
    input  logic [HW-1:0]            base,
    output logic signed [ACC_W-1:0]  sum_re,
    output logic signed [ACC_W-1:0]  sum_im
);

    localparam int PW = 2 * SAMP_W + 1;

    logic signed [PW-1:0] p_re [TAPS];
    logic signed [PW-1:0] p_im [TAPS];

    for (genvar j = 0; j < TAPS; j++) begin : g_tap
        logic [HW-1:0]        idx;
        logic [SW-1:0]        smp;
        logic signed [PW-1:0] a_re, a_im, c_re, c_im;

        assign idx  = base + HW'(j);
        assign smp  = hist_flat[idx*SW +: SW];
        assign a_re = {{(PW-SAMP_W){smp[SW-1]}}, smp[SW-1:SAMP_W]};
        assign a_im = {{(PW-SAMP_W){smp[SAMP_W-1]}}, smp[SAMP_W-1:0]};
        assign c_re = {{(PW-SAMP_W){COEFS[j*SW+SW-1]}}, COEFS[j*SW+SAMP_W +: SAMP_W]};
        assign c_im = {{(PW-SAMP_W){COEFS[j*SW+SAMP_W-1]}}, COEFS[j*SW +: SAMP_W]};
        assign p_re[j] = a_re * c_re - a_im * c_im;
        assign p_im[j] = a_re * c_im + a_im * c_re;
    end

    always_comb begin
        sum_re = '0;
        sum_im = '0;
        for (int j = 0; j < TAPS; j++) begin
            sum_re = sum_re + {{(ACC_W-PW){p_re[j][PW-1]}}, p_re[j]};
            sum_im = sum_im + {{(ACC_W-PW){p_im[j][PW-1]}}, p_im[j]};
        end
    end

endmodule

// File: rtl/cfir_out_conv.sv
module cfir_out_conv #(
    parameter int LANES  = 4,
    parameter int SAMP_W = 16,
    parameter int ACC_W  = 48,
    parameter int SHIFT  = 15
)(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [LANES*2*ACC_W-1:0]  acc_flat,
    output logic [LANES*2*SAMP_W-1:0] smp_flat
);

    localparam logic signed [ACC_W:0] HALF =
        (SHIFT > 0) ? ((ACC_W+1)'(1) << ((SHIFT > 0) ? SHIFT - 1 : 0)) : '0;
    localparam logic signed [ACC_W:0] MAXV = (ACC_W+1)'((2 ** (SAMP_W - 1)) - 1);
    localparam logic signed [ACC_W:0] MINV = -((ACC_W+1)'(2 ** (SAMP_W - 1)));

    function automatic logic [SAMP_W-1:0] squash(input logic signed [ACC_W-1:0] v);
        logic signed [ACC_W:0] t;
        t = {v[ACC_W-1], v} + HALF;
        t = t >>> SHIFT;
        if (t > MAXV)      return MAXV[SAMP_W-1:0];
        else if (t < MINV) return MINV[SAMP_W-1:0];
        else               return t[SAMP_W-1:0];
    endfunction

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic signed [ACC_W-1:0] in_re, in_im;
        logic [SAMP_W-1:0]       o_re, o_im;

        assign in_re = acc_flat[l*2*ACC_W + ACC_W +: ACC_W];
        assign in_im = acc_flat[l*2*ACC_W +: ACC_W];
        assign o_re  = squash(in_re);
        assign o_im  = squash(in_im);
        assign smp_flat[l*2*SAMP_W + SAMP_W +: SAMP_W] = o_re;
        assign smp_flat[l*2*SAMP_W +: SAMP_W]          = o_im;

        // R5: rounding and clamping never turn a non-negative sum negative
        a_r5_sign_kept_re: assert property (@(posedge clk) disable iff (!rst_n)
            !in_re[ACC_W-1] |-> !o_re[SAMP_W-1]);
        a_r5_sign_kept_im: assert property (@(posedge clk) disable iff (!rst_n)
            !in_im[ACC_W-1] |-> !o_im[SAMP_W-1]);
    end

endmodule

// File: rtl/cfir_segment.sv
module cfir_segment
    import cfir_pkg::*;
#(
    parameter int SEG_IDX = 0,
    parameter int NUM_SEG = 4,
    parameter int TAPS    = 8,
    parameter int LANES   = 4,
    parameter int SAMP_W  = 16,
    parameter int ACC_W   = 48,
    parameter int SHIFT   = 15,
    parameter logic [TAPS*2*SAMP_W-1:0] COEFS = {TAPS{SAMP_W'(1), SAMP_W'(0)}},
    localparam int OUT_W = (SEG_IDX == NUM_SEG - 1) ? LANES*2*SAMP_W : LANES*2*ACC_W
)(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     smp_valid,
    input  logic [2*SAMP_W-1:0]      smp_data,
    output logic                     smp_ready,
    input  logic                     casc_valid,
    input  logic [LANES*2*ACC_W-1:0] casc_data,
    output logic                     casc_ready,
    output logic                     out_valid,
    output logic [OUT_W-1:0]         out_data,
    input  logic                     out_ready
);

    localparam bit IS_FIRST = (SEG_IDX == 0);
    localparam bit IS_LAST  = (SEG_IDX == NUM_SEG - 1);
    localparam int HIST_N   = QUARTERS * LANES;
    localparam int HW       = $clog2(HIST_N);
    localparam int CW       = $clog2(LANES + 1);
    localparam int LW       = $clog2(LANES);
    localparam int SKIP_N   = TAPS * SEG_IDX;
    localparam int CNT_W    = $clog2(TAPS * (SEG_IDX + 1) + 1);
    localparam int SW       = 2 * SAMP_W;
    localparam seg_state_t INIT_ST = (SKIP_N == 0) ? ST_FILL : ST_SKIP;

    seg_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [LW-1:0]    lane_q, lane_d;
    logic [1:0]       step_q, step_d;

    logic                  smp_fire, fill_we, stage_push, step_go;
    logic [CW-1:0]         stage_cnt;
    logic [HIST_N*SW-1:0]  hist_flat;
    logic [HW-1:0]         mac_base;
    logic signed [ACC_W-1:0] mac_re, mac_im;
    logic signed [ACC_W-1:0] acc_re [LANES];
    logic signed [ACC_W-1:0] acc_im [LANES];
    logic [LANES*2*ACC_W-1:0] acc_flat;

    assign smp_fire = smp_valid && smp_ready;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= INIT_ST;
            cnt_q   <= '0;
            lane_q  <= '0;
            step_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            lane_q  <= lane_d;
            step_q  <= step_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        lane_d  = lane_q;
        step_d  = step_q;
        unique case (state_q)
            ST_SKIP: if (smp_fire) begin
                if (cnt_q == CNT_W'(SKIP_N - 1)) begin
                    cnt_d   = '0;
                    state_d = ST_FILL;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_FILL: if (smp_fire) begin
                if (cnt_q == CNT_W'(TAPS - 1)) begin
                    cnt_d   = '0;
                    state_d = ST_WAIT;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_WAIT: if (step_go) begin
                lane_d  = '0;
                state_d = ST_CALC;
            end
            ST_CALC: begin
                if (lane_q == LW'(LANES - 1)) state_d = ST_SEND;
                else                          lane_d  = lane_q + 1'b1;
            end
            ST_SEND: if (out_ready) begin
                step_d  = step_q + 1'b1;
                state_d = ST_WAIT;
            end
            default: state_d = INIT_ST;
        endcase
    end

    // outputs and strobes
    always_comb begin
        smp_ready  = 1'b0;
        casc_ready = 1'b0;
        out_valid  = 1'b0;
        fill_we    = 1'b0;
        stage_push = 1'b0;
        step_go    = 1'b0;
        unique case (state_q)
            ST_SKIP: smp_ready = 1'b1;
            ST_FILL: begin
                smp_ready = 1'b1;
                fill_we   = smp_valid;
            end
            ST_WAIT: begin
                smp_ready  = (stage_cnt != CW'(LANES));
                stage_push = smp_fire;
                step_go    = (stage_cnt == CW'(LANES)) && (IS_FIRST || casc_valid);
                casc_ready = !IS_FIRST && (stage_cnt == CW'(LANES));
            end
            ST_CALC: begin
                smp_ready  = (stage_cnt != CW'(LANES));
                stage_push = smp_fire;
            end
            ST_SEND: begin
                smp_ready  = (stage_cnt != CW'(LANES));
                stage_push = smp_fire;
                out_valid  = 1'b1;
            end
            default: ;
        endcase
    end

    cfir_history #(
        .LANES  (LANES),
        .SAMP_W (SAMP_W)
    ) u_hist (
        .clk        (clk),
        .rst_n      (rst_n),
        .din        (smp_data),
        .fill_we    (fill_we),
        .fill_idx   (HW'(cnt_q)),
        .stage_push (stage_push),
        .commit     (step_go),
        .quarter    (step_q + 2'd2),
        .hist_flat  (hist_flat),
        .stage_cnt  (stage_cnt)
    );

    assign mac_base = HW'(int'(step_q) * LANES + int'(lane_q));

    cfir_lane_mac #(
        .TAPS   (TAPS),
        .LANES  (LANES),
        .SAMP_W (SAMP_W),
        .ACC_W  (ACC_W),
        .COEFS  (COEFS)
    ) u_mac (
        .hist_flat (hist_flat),
        .base      (mac_base),
        .sum_re    (mac_re),
        .sum_im    (mac_im)
    );

    // accumulators: seeded at step start, one lane updated per ST_CALC cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int l = 0; l < LANES; l++) begin
                acc_re[l] <= '0;
                acc_im[l] <= '0;
            end
        end else if (step_go) begin
            for (int l = 0; l < LANES; l++) begin
                if (IS_FIRST) begin
                    acc_re[l] <= '0;
                    acc_im[l] <= '0;
                end else begin
                    acc_re[l] <= casc_data[l*2*ACC_W + ACC_W +: ACC_W];
                    acc_im[l] <= casc_data[l*2*ACC_W +: ACC_W];
                end
            end
        end else if (state_q == ST_CALC) begin
            acc_re[lane_q] <= acc_re[lane_q] + mac_re;
            acc_im[lane_q] <= acc_im[lane_q] + mac_im;
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_pack
        assign acc_flat[l*2*ACC_W + ACC_W +: ACC_W] = acc_re[l];
        assign acc_flat[l*2*ACC_W +: ACC_W]         = acc_im[l];
    end

    if (IS_LAST) begin : g_last
        cfir_out_conv #(
            .LANES  (LANES),
            .SAMP_W (SAMP_W),
            .ACC_W  (ACC_W),
            .SHIFT  (SHIFT)
        ) u_conv (
            .clk      (clk),
            .rst_n    (rst_n),
            .acc_flat (acc_flat),
            .smp_flat (out_data)
        );
    end else begin : g_fwd
        assign out_data = acc_flat;
    end

    // R8: an offered result is held until taken
    a_r8_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    // R1: priming writes stay inside the first half of the history
    a_r1_fill_range: assert property (@(posedge clk) disable iff (!rst_n)
        fill_we |-> (cnt_q < CNT_W'(TAPS)));

    // R4: no cascade vector is taken while a result is still pending
    a_r4_casc_gap: assert property (@(posedge clk) disable iff (!rst_n)
        casc_valid && casc_ready |-> !out_valid);

endmodule

// File: tb/cfir_segment_test.sv
`timescale 1ns/1ps
module cfir_segment_test;

    localparam int BSH = 4;
    localparam int NSTEP = 6;
    localparam longint CR [0:NSTEP-1] = '{1000, -5000, 123, 0, 64'sd1099511627776, 8};
    localparam longint CI [0:NSTEP-1] = '{-700, 3000, 45, 999, -64'sd1099511627776, -8};

    function automatic logic [255:0] mk_coefs();
        logic [255:0] r;
        r = '0;
        for (int j = 0; j < 8; j++) begin
            r[j*32+16 +: 16] = 16'(3*j - 5);
            r[j*32 +: 16]    = 16'(7 - 2*j);
        end
        return r;
    endfunction
    localparam logic [255:0] BCOEF = mk_coefs();

    logic clk = 0;
    logic rst_n = 0;
    always #2.5 clk = ~clk;

    logic         in_valid = 0, sel = 0;
    logic [31:0]  in_data = '0;
    logic         uut_in_ready, head_in_ready;
    logic         uut_casc_valid = 0, uut_casc_ready;
    logic [383:0] uut_casc_data = '0;
    logic         uut_out_valid, uut_out_ready = 0;
    logic [127:0] uut_out_data;
    logic         head_casc_ready, head_out_valid, head_out_ready = 0;
    logic [383:0] head_out_data;

    cfir_segment #(.SEG_IDX(1), .NUM_SEG(2), .SHIFT(BSH), .COEFS(BCOEF)) uut (
        .clk(clk), .rst_n(rst_n),
        .smp_valid(in_valid && !sel), .smp_data(in_data), .smp_ready(uut_in_ready),
        .casc_valid(uut_casc_valid), .casc_data(uut_casc_data), .casc_ready(uut_casc_ready),
        .out_valid(uut_out_valid), .out_data(uut_out_data), .out_ready(uut_out_ready));

    cfir_segment #(.SEG_IDX(0), .NUM_SEG(2), .SHIFT(BSH), .COEFS(BCOEF)) u_head (
        .clk(clk), .rst_n(rst_n),
        .smp_valid(in_valid && sel), .smp_data(in_data), .smp_ready(head_in_ready),
        .casc_valid(1'b1), .casc_data({384{1'b1}}), .casc_ready(head_casc_ready),
        .out_valid(head_out_valid), .out_data(head_out_data), .out_ready(head_out_ready));

    int total = 0, bad = 0;
    bit done = 0;

    task automatic chk(input string tag, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic longint xre(int n);
        if (n >= 24 && n < 40) return 0;
        return longint'((n * 53) % 401) - 200;
    endfunction
    function automatic longint xim(int n);
        if (n >= 24 && n < 40) return 0;
        return longint'((n * 29) % 301) - 150;
    endfunction

    // filter model: first sample index 'first', step t, lane l
    task automatic model(input int first, input int t, input int l,
                         output longint sre, output longint sim);
        sre = 0; sim = 0;
        for (int j = 0; j < 8; j++) begin
            longint ar, ai, cr, ci;
            ar = xre(first + 4*t + l + j);
            ai = xim(first + 4*t + l + j);
            cr = 3*j - 5;
            ci = 7 - 2*j;
            sre += ar*cr - ai*ci;
            sim += ar*ci + ai*cr;
        end
    endtask

    function automatic longint squash(longint v);
        longint r;
        r = (v + (64'sd1 <<< (BSH-1))) >>> BSH;
        if (r > 32767) r = 32767;
        if (r < -32768) r = -32768;
        return r;
    endfunction

    task automatic push(input int n);
        logic r;
        in_data  = {16'(xre(n)), 16'(xim(n))};
        in_valid = 1;
        do begin
            r = sel ? head_in_ready : uut_in_ready;
            @(negedge clk);
        end while (!r);
        in_valid = 0;
    endtask

    task automatic check_head(input int t);
        for (int l = 0; l < 4; l++) begin
            longint er, ei;
            model(0, t, l, er, ei);
            chk($sformatf("R2 R11 head step%0d lane%0d re", t, l),
                longint'($signed(head_out_data[96*l+48 +: 48])), er);
            chk($sformatf("R3 R6 head step%0d lane%0d im", t, l),
                longint'($signed(head_out_data[96*l +: 48])), ei);
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL R7 watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R10 reset state
        chk("R10 uut out_valid", uut_out_valid, 0);
        chk("R10 head out_valid", head_out_valid, 0);
        chk("R10 uut casc_ready", uut_casc_ready, 0);
        chk("R10 uut smp_ready", uut_in_ready, 1);
        chk("R10 head smp_ready", head_in_ready, 1);
        rst_n = 1;
        @(negedge clk);

        // first slice: latency, full-width output, cascade ignored
        sel = 1;
        for (int n = 0; n < 12; n++) push(n);
        for (int k = 1; k <= 5; k++) begin
            @(negedge clk);
            chk($sformatf("R9 head out_valid after %0d edges", k), head_out_valid, (k == 5) ? 1 : 0);
            chk("R6 head casc_ready", head_casc_ready, 0);
        end
        check_head(0);
        head_out_ready = 1;
        @(negedge clk);
        head_out_ready = 0;
        for (int n = 12; n < 16; n++) push(n);
        while (!head_out_valid) begin
            chk("R6 head casc_ready", head_casc_ready, 0);
            @(negedge clk);
        end
        check_head(1);

        // last slice: skip, cascade add, rounding, saturation, back-pressure
        sel = 0;
        fork
            begin
                for (int n = 0; n < 40; n++) push(n);
            end
            begin
                for (int t = 0; t < NSTEP; t++) begin
                    logic r;
                    for (int l = 0; l < 4; l++) begin
                        uut_casc_data[96*l+48 +: 48] = 48'(CR[t] + 16*l);
                        uut_casc_data[96*l +: 48]    = 48'(CI[t] - 16*l);
                    end
                    uut_casc_valid = 1;
                    do begin
                        r = uut_casc_ready;
                        @(negedge clk);
                    end while (!r);
                    uut_casc_valid = 0;
                end
            end
            begin
                for (int t = 0; t < NSTEP; t++) begin
                    while (!uut_out_valid) @(negedge clk);
                    for (int l = 0; l < 4; l++) begin
                        longint er, ei;
                        model(8, t, l, er, ei);
                        er = squash(er + CR[t] + 16*l);
                        ei = squash(ei + CI[t] - 16*l);
                        chk($sformatf("R1 R4 R5 uut step%0d lane%0d re", t, l),
                            longint'($signed(uut_out_data[32*l+16 +: 16])), er);
                        chk($sformatf("R2 R3 uut step%0d lane%0d im", t, l),
                            longint'($signed(uut_out_data[32*l +: 16])), ei);
                    end
                    if (t == 4) begin
                        chk("R5 saturate high", longint'($signed(uut_out_data[31:16])), 32767);
                        chk("R5 saturate low", longint'($signed(uut_out_data[15:0])), -32768);
                    end
                    if (t == 5) begin
                        for (int l = 0; l < 4; l++) begin
                            chk($sformatf("R5 round half up re lane%0d", l),
                                longint'($signed(uut_out_data[32*l+16 +: 16])), 1 + l);
                            chk($sformatf("R5 round half up im lane%0d", l),
                                longint'($signed(uut_out_data[32*l +: 16])), -l);
                        end
                    end
                    if (t == 2) begin
                        logic [127:0] snap;
                        snap = uut_out_data;
                        repeat (8) begin
                            @(negedge clk);
                            chk("R8 held valid", uut_out_valid, 1);
                            chk("R8 held data", (uut_out_data == snap) ? 1 : 0, 1);
                        end
                        chk("R7 smp_ready low with full staging", uut_in_ready, 0);
                    end
                    uut_out_ready = 1;
                    @(negedge clk);
                    uut_out_ready = 0;
                end
            end
        join

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule